// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This block keeps track of which operating mode a small processor core is in: run, wait, stop, or active background (debug). It takes single-cycle strobes for decoded WAIT and STOP instructions and for a debug BACKGROUND command. It also takes a debug-enable level, two low-voltage-detect enable levels, two stop-mode clock-source configuration levels, an enabled-interrupt indication and a synchronous system reset request. From these it drives the control lines of each power domain: the CPU clock gate, the flash standby request, the oscillator and internal clock source enables, the regulator mode, the low-power oscillator enable and the debug clock keep-alive.

When either low-power mode is entered, the controller raises a one-cycle request to clear the interrupt mask. While the core waits or stops, it turns away debug memory-access-with-status commands: instead of performing the access, it returns an error strobe.

Whether the regulator stays in full regulation and whether the debug clocks keep running in stop is fixed by the configuration levels present on the cycle STOP executes. The oscillator and internal clock source enables are fixed the same way. Later changes to these levels have no effect until the next STOP.

Leaving stop on an interrupt passes through a recovery window of `RECOV_CYC` cycles before the CPU clock is ungated. Leaving wait ungates the CPU clock on the next cycle.

Top module: `lpm_seq_ctrl`

## Requirements
- R1: `mode` reports run=0, wait=1, stop=2, background=3. From run, a `stop_exec` strobe enters stop and a `wait_exec` strobe enters wait, visible one cycle later. When both strobes arrive together, stop wins.
- R2: `imask_clr` is high for exactly the first cycle of every entry into wait or stop, and is low at all other times.
- R3: In run and background, every domain is on. That means `cpu_clk_en`=1, `flash_stby`=0, `osc_en`=1, `ics_en`=1, `reg_full`=1 and `dbg_clk_en`=1. In wait the same holds, except that `cpu_clk_en`=0. While `rst_n` is low, the block is in run with this all-on state.
- R4: In stop, `cpu_clk_en`=0 and `flash_stby`=1. `reg_full` is 1 if `dbg_en` was set when STOP executed, or if both `lvd_en` and `lvd_stop_en` were set then; otherwise `reg_full` is 0 (loose regulation). `dbg_clk_en` equals the `dbg_en` value sampled when STOP executed.
- R5: In stop, `osc_en` and `ics_en` equal `osc_stop_en` and `ics_stop_en` as sampled when STOP executed. Changing any configuration input during stop has no effect on the stop-mode outputs.
- R6: In wait, `irq` returns the block to run with `cpu_clk_en`=1 one cycle later.
- R7: In stop, `irq` moves `mode` to run one cycle later. The other domains come back on at once, but `cpu_clk_en` stays 0 until exactly `RECOV_CYC`+1 cycles after the cycle `irq` was presented. During this recovery window, `irq`, `bkgd_cmd`, `wait_exec` and `stop_exec` are ignored.
- R8: A `bkgd_cmd` strobe enters background one cycle later, with every domain on. In run or wait this needs the live `dbg_en`; in stop it needs the `dbg_en` value sampled at STOP. The strobe takes priority over `irq`, `wait_exec` and `stop_exec`. Without the required enable, `bkgd_cmd` is ignored and the mode is unchanged.
- R9: A `dbg_mem_req` strobe gives, one cycle later, `dbg_mem_err`=1 if the block was in wait or stop, and `dbg_mem_go`=1 otherwise. The two strobes are never high together.
- R10: `rst_req` has priority over every other input. One cycle later the block is in run with all domains on, from any mode. Background is left only through `rst_req`; `irq`, `wait_exec` and `stop_exec` have no effect there.
- R11: `lpo_en` is 1 in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| rst_req | input | 1 | Synchronous system reset request, highest priority |
| wait_exec | input | 1 | WAIT instruction executed (strobe) |
| stop_exec | input | 1 | STOP instruction executed (strobe) |
| bkgd_cmd | input | 1 | Debug BACKGROUND command received (strobe) |
| dbg_en | input | 1 | Debug enable level |
| lvd_en | input | 1 | Low-voltage detect enable |
| lvd_stop_en | input | 1 | Low-voltage detect kept in stop |
| osc_stop_en | input | 1 | Keep oscillator on in stop |
| ics_stop_en | input | 1 | Keep internal clock source on in stop |
| irq | input | 1 | Enabled interrupt pending |
| dbg_mem_req | input | 1 | Debug memory-access-with-status command (strobe) |
| mode | output | 2 | Current mode: 0 run, 1 wait, 2 stop, 3 background |
| cpu_clk_en | output | 1 | CPU clock enable |
| flash_stby | output | 1 | Flash standby request |
| osc_en | output | 1 | Oscillator enable |
| ics_en | output | 1 | Internal clock source enable |
| reg_full | output | 1 | Regulator full regulation (0 = loose) |
| lpo_en | output | 1 | Low-power oscillator enable |
| dbg_clk_en | output | 1 | Debug logic clock keep-alive |
| imask_clr | output | 1 | Clear interrupt mask (one-cycle pulse) |
| dbg_mem_err | output | 1 | Debug access refused, low-power mode error |
| dbg_mem_go | output | 1 | Debug access performed |

## Verification
Every strobe or level is sampled on one clock edge. The mode and all domain outputs reflect it right after that edge; this includes the interrupt-mask pulse and the debug access verdict. The exception is the CPU clock after a stop exit, which stays gated through the recovery window and rises `RECOV_CYC`+1 cycles after the interrupt was presented. The driver applies inputs just after a rising edge. For each expected item it queues the exact cycle at which the item is due. The monitor compares only at the falling edge of that cycle, so each check lands one cycle after its stimulus. The recovery check lands at both the last gated cycle and the first ungated one.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [1:0] {
        MODE_RUN  = 2'd0,
        MODE_WAIT = 2'd1,
        MODE_STOP = 2'd2,
        MODE_BKGD = 2'd3
    } lpm_mode_e;

    typedef enum logic [2:0] {
        ST_RUN   = 3'd0,
        ST_WAIT  = 3'd1,
        ST_STOP  = 3'd2,
        ST_BKGD  = 3'd3,
        ST_RECOV = 3'd4
    } lpm_state_e;

    // configuration captured on the cycle STOP executes
    typedef struct packed {
        logic dbg;       // debug clocks and full regulator kept
        logic lvd_keep;  // low-voltage detect keeps regulator full
        logic osc;       // oscillator stays on
        logic ics;       // internal clock source stays on
    } stop_cfg_t;

    typedef struct packed {
        logic cpu_clk_en;
        logic flash_stby;
        logic osc_en;
        logic ics_en;
        logic reg_full;
        logic lpo_en;
        logic dbg_clk_en;
    } dom_ctl_t;

    localparam dom_ctl_t DOM_ALL_ON = '{
        cpu_clk_en: 1'b1, flash_stby: 1'b0, osc_en: 1'b1, ics_en: 1'b1,
        reg_full: 1'b1, lpo_en: 1'b1, dbg_clk_en: 1'b1
    };

endpackage

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
    import lpm_pkg::*;
#(
    parameter int RECOV_CYC = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      rst_req,
    input  logic      wait_exec,
    input  logic      stop_exec,
    input  logic      bkgd_cmd,
    input  logic      dbg_en,
    input  logic      lvd_en,
    input  logic      lvd_stop_en,
    input  logic      osc_stop_en,
    input  logic      ics_stop_en,
    input  logic      irq,
    output lpm_mode_e mode_o,
    output logic      recov_o,
    output stop_cfg_t cfg_o,
    output logic      imask_clr_o
);

    localparam int CW = (RECOV_CYC < 2) ? 1 : $clog2(RECOV_CYC);
    localparam logic [CW-1:0] CNT_LOAD = CW'(RECOV_CYC - 1);

    typedef struct packed {
        lpm_state_e      st;
        logic [CW-1:0]   cnt;
        stop_cfg_t       cfg;
        logic            imask;
    } fsm_t;

    fsm_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.imask = 1'b0;
        unique case (s_q.st)
            ST_RUN: begin
                if (bkgd_cmd && dbg_en) begin
                    s_d.st = ST_BKGD;
                end else if (stop_exec) begin
                    s_d.st           = ST_STOP;
                    s_d.imask        = 1'b1;
                    s_d.cfg.dbg      = dbg_en;
                    s_d.cfg.lvd_keep = lvd_en && lvd_stop_en;
                    s_d.cfg.osc      = osc_stop_en;
                    s_d.cfg.ics      = ics_stop_en;
                end else if (wait_exec) begin
                    s_d.st    = ST_WAIT;
                    s_d.imask = 1'b1;
                end
            end
            ST_WAIT: begin
                if (bkgd_cmd && dbg_en) begin
                    s_d.st = ST_BKGD;
                end else if (irq) begin
                    s_d.st = ST_RUN;
                end
            end
            ST_STOP: begin
                if (bkgd_cmd && s_q.cfg.dbg) begin
                    s_d.st = ST_BKGD;
                end else if (irq) begin
                    s_d.st  = ST_RECOV;
                    s_d.cnt = CNT_LOAD;
                end
            end
            ST_RECOV: begin
                if (s_q.cnt == '0) begin
                    s_d.st = ST_RUN;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            ST_BKGD: begin
                s_d.st = ST_BKGD;
            end
            default: begin
                s_d.st = ST_RUN;
            end
        endcase
        if (rst_req) begin
            s_d.st    = ST_RUN;
            s_d.cnt   = '0;
            s_d.imask = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_RUN, cnt: '0, cfg: '0, imask: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        unique case (s_q.st)
            ST_WAIT:  mode_o = MODE_WAIT;
            ST_STOP:  mode_o = MODE_STOP;
            ST_BKGD:  mode_o = MODE_BKGD;
            default:  mode_o = MODE_RUN;
        endcase
    end

    assign recov_o     = (s_q.st == ST_RECOV);
    assign cfg_o       = s_q.cfg;
    assign imask_clr_o = s_q.imask;

    // R5: captured configuration holds for the whole stay in stop
    a_r5_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_STOP && $past(s_q.st) == ST_STOP) |-> $stable(s_q.cfg));

    // R7: the recovery window always ends in run
    a_r7_recov_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_RECOV && s_q.cnt == '0) |=> (s_q.st == ST_RUN));

endmodule

// File: rtl/lpm_domain_ctl.sv
module lpm_domain_ctl
    import lpm_pkg::*;
(
    input  lpm_mode_e mode_i,
    input  logic      recov_i,
    input  stop_cfg_t cfg_i,
    output dom_ctl_t  dom_o
);

    always_comb begin
        dom_o = DOM_ALL_ON;
        unique case (mode_i)
            MODE_WAIT: begin
                dom_o.cpu_clk_en = 1'b0;
            end
            MODE_STOP: begin
                dom_o.cpu_clk_en = 1'b0;
                dom_o.flash_stby = 1'b1;
                dom_o.osc_en     = cfg_i.osc;
                dom_o.ics_en     = cfg_i.ics;
                dom_o.reg_full   = cfg_i.dbg || cfg_i.lvd_keep;
                dom_o.dbg_clk_en = cfg_i.dbg;
            end
            default: begin
                dom_o.cpu_clk_en = !recov_i;
            end
        endcase
    end

endmodule

// File: rtl/lpm_dbg_gate.sv
module lpm_dbg_gate
    import lpm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req_i,
    input  lpm_mode_e mode_i,
    output logic      err_o,
    output logic      go_o
);

    typedef struct packed {
        logic err;
        logic go;
    } gate_t;

    gate_t g_d, g_q;

    always_comb begin
        logic low_pwr;
        low_pwr = (mode_i == MODE_WAIT) || (mode_i == MODE_STOP);
        g_d.err = req_i && low_pwr;
        g_d.go  = req_i && !low_pwr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q <= '0;
        end else begin
            g_q <= g_d;
        end
    end

    assign err_o = g_q.err;
    assign go_o  = g_q.go;

    // R9: a refused access never also proceeds
    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_o && go_o));

    // R9: every request yields exactly one verdict on the next cycle
    a_r9_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> (err_o || go_o));

endmodule

// File: rtl/lpm_seq_ctrl.sv
module lpm_seq_ctrl
    import lpm_pkg::*;
#(
    parameter int RECOV_CYC = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rst_req,
    input  logic       wait_exec,
    input  logic       stop_exec,
    input  logic       bkgd_cmd,
    input  logic       dbg_en,
    input  logic       lvd_en,
    input  logic       lvd_stop_en,
    input  logic       osc_stop_en,
    input  logic       ics_stop_en,
    input  logic       irq,
    input  logic       dbg_mem_req,
    output logic [1:0] mode,
    output logic       cpu_clk_en,
    output logic       flash_stby,
    output logic       osc_en,
    output logic       ics_en,
    output logic       reg_full,
    output logic       lpo_en,
    output logic       dbg_clk_en,
    output logic       imask_clr,
    output logic       dbg_mem_err,
    output logic       dbg_mem_go
);

    lpm_mode_e mode_w;
    logic      recov_w;
    stop_cfg_t cfg_w;
    dom_ctl_t  dom_w;

    lpm_mode_fsm #(.RECOV_CYC(RECOV_CYC)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .rst_req     (rst_req),
        .wait_exec   (wait_exec),
        .stop_exec   (stop_exec),
        .bkgd_cmd    (bkgd_cmd),
        .dbg_en      (dbg_en),
        .lvd_en      (lvd_en),
        .lvd_stop_en (lvd_stop_en),
        .osc_stop_en (osc_stop_en),
        .ics_stop_en (ics_stop_en),
        .irq         (irq),
        .mode_o      (mode_w),
        .recov_o     (recov_w),
        .cfg_o       (cfg_w),
        .imask_clr_o (imask_clr)
    );

    lpm_domain_ctl u_dom (
        .mode_i  (mode_w),
        .recov_i (recov_w),
        .cfg_i   (cfg_w),
        .dom_o   (dom_w)
    );

    lpm_dbg_gate u_dbg (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (dbg_mem_req),
        .mode_i (mode_w),
        .err_o  (dbg_mem_err),
        .go_o   (dbg_mem_go)
    );

    assign mode       = mode_w;
    assign cpu_clk_en = dom_w.cpu_clk_en;
    assign flash_stby = dom_w.flash_stby;
    assign osc_en     = dom_w.osc_en;
    assign ics_en     = dom_w.ics_en;
    assign reg_full   = dom_w.reg_full;
    assign lpo_en     = dom_w.lpo_en;
    assign dbg_clk_en = dom_w.dbg_clk_en;

    // R2: mask-clear pulse lasts one cycle and only marks a low-power entry
    a_r2_imask_single: assert property (@(posedge clk) disable iff (!rst_n)
        imask_clr |=> !imask_clr);
    a_r2_imask_entry: assert property (@(posedge clk) disable iff (!rst_n)
        imask_clr |-> (mode == 2'd1 || mode == 2'd2));

    // R6: interrupt in wait restores the CPU clock on the next cycle
    a_r6_wait_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1 && irq && !rst_req && !(bkgd_cmd && dbg_en))
        |=> (mode == 2'd0 && cpu_clk_en));

    // R7: interrupt in stop leaves the CPU clock gated at first
    a_r7_stop_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 && irq && !rst_req && !(bkgd_cmd && dbg_clk_en))
        |=> (mode == 2'd0 && !cpu_clk_en && reg_full && !flash_stby));

    // R10: reset request forces run with every domain on
    a_r10_reset: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> (mode == 2'd0 && cpu_clk_en && !flash_stby && osc_en
                     && ics_en && reg_full && dbg_clk_en));

    // R3: outside stop the flash is never in standby
    a_r3_flash_on: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'd2) |-> !flash_stby);

endmodule

// File: tb/tb_lpm_seq_ctrl.sv
module tb_lpm_seq_ctrl;

    localparam int RC = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rst_req = 0, wait_exec = 0, stop_exec = 0, bkgd_cmd = 0;
    logic dbg_en = 0, lvd_en = 0, lvd_stop_en = 0, osc_stop_en = 0, ics_stop_en = 0;
    logic irq = 0, dbg_mem_req = 0;
    logic [1:0] mode;
    logic cpu_clk_en, flash_stby, osc_en, ics_en, reg_full, lpo_en, dbg_clk_en;
    logic imask_clr, dbg_mem_err, dbg_mem_go;

    lpm_seq_ctrl #(.RECOV_CYC(RC)) dut (
        .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .wait_exec(wait_exec),
        .stop_exec(stop_exec), .bkgd_cmd(bkgd_cmd), .dbg_en(dbg_en),
        .lvd_en(lvd_en), .lvd_stop_en(lvd_stop_en), .osc_stop_en(osc_stop_en),
        .ics_stop_en(ics_stop_en), .irq(irq), .dbg_mem_req(dbg_mem_req),
        .mode(mode), .cpu_clk_en(cpu_clk_en), .flash_stby(flash_stby),
        .osc_en(osc_en), .ics_en(ics_en), .reg_full(reg_full), .lpo_en(lpo_en),
        .dbg_clk_en(dbg_clk_en), .imask_clr(imask_clr),
        .dbg_mem_err(dbg_mem_err), .dbg_mem_go(dbg_mem_go)
    );

    always #4 clk = ~clk;   // 125 MHz

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int          due;
        logic [11:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];
    int n_chk = 0;
    int n_bad = 0;

    // {mode, cpu, flash_stby, osc, ics, reg_full, lpo, dbg_clk, imask, err, go}
    function automatic logic [11:0] ev(logic [1:0] m, logic cpu, logic fs, logic osc,
                                       logic ics, logic rg, logic dc, logic im,
                                       logic er, logic go);
        return {m, cpu, fs, osc, ics, rg, 1'b1, dc, im, er, go};
    endfunction

    localparam logic [11:0] RUN_ALL = {2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0};

    task automatic expect_at(int d, logic [11:0] e, string tag);
        item_t it;
        it.due = cyc + d;
        it.exp = e;
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
        rst_req = 0; wait_exec = 0; stop_exec = 0; bkgd_cmd = 0;
        irq = 0; dbg_mem_req = 0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    // monitor: compare items on their due cycle, away from the active edge
    always @(negedge clk) begin
        logic [11:0] obs;
        obs = {mode, cpu_clk_en, flash_stby, osc_en, ics_en, reg_full, lpo_en,
               dbg_clk_en, imask_clr, dbg_mem_err, dbg_mem_go};
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            item_t it;
            it = sb.pop_front();
            n_chk++;
            if (it.due != cyc || obs !== it.exp) begin
                n_bad++;
                $display("FAIL %s: cycle %0d actual %b expected %b", it.tag, cyc, obs, it.exp);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
        $finish;
    end

    initial begin
        tick();
        expect_at(0, RUN_ALL, "R3 R11 reset state");
        tick();
        rst_n = 1'b1;

        // R9 access allowed in run
        tick(); dbg_mem_req = 1;
        expect_at(1, ev(2'd0, 1, 0, 1, 1, 1, 1, 0, 0, 1), "R9 run access performed");

        // R1 R2 R3 wait entry
        tick(); wait_exec = 1;
        expect_at(1, ev(2'd1, 0, 0, 1, 1, 1, 1, 1, 0, 0), "R1 R2 R3 wait entry");
        tick(); dbg_mem_req = 1;
        expect_at(1, ev(2'd1, 0, 0, 1, 1, 1, 1, 0, 1, 0), "R2 R9 pulse ended, wait refuses");
        tick(); irq = 1;
        expect_at(1, RUN_ALL, "R6 wait exit");

        // R4 R5 stop, everything loose
        tick(); dbg_en = 0; lvd_en = 0; lvd_stop_en = 0;
        osc_stop_en = 1; ics_stop_en = 0; stop_exec = 1;
        expect_at(1, ev(2'd2, 0, 1, 1, 0, 0, 0, 1, 0, 0), "R4 R5 stop entry");
        tick(); osc_stop_en = 0; ics_stop_en = 1; dbg_en = 1; bkgd_cmd = 1;
        expect_at(1, ev(2'd2, 0, 1, 1, 0, 0, 0, 0, 0, 0), "R5 R8 changes and background ignored");
        tick(); dbg_mem_req = 1;
        expect_at(1, ev(2'd2, 0, 1, 1, 0, 0, 0, 0, 1, 0), "R9 stop refuses");
        tick(); dbg_en = 0; irq = 1;
        expect_at(1, ev(2'd0, 0, 0, 1, 1, 1, 1, 0, 0, 0), "R7 recovery gated");
        expect_at(RC, ev(2'd0, 0, 0, 1, 1, 1, 1, 0, 0, 0), "R7 last gated cycle");
        expect_at(RC + 1, RUN_ALL, "R7 clock restored");
        repeat (RC + 1) tick();

        // R4 low-voltage detect without stop enable -> loose
        tick(); lvd_en = 1; lvd_stop_en = 0; osc_stop_en = 1; ics_stop_en = 1; stop_exec = 1;
        expect_at(1, ev(2'd2, 0, 1, 1, 1, 0, 0, 1, 0, 0), "R4 partial lvd loose");
        tick(); rst_req = 1; irq = 1;
        expect_at(1, RUN_ALL, "R10 reset from stop");
        tick(); lvd_stop_en = 1; stop_exec = 1;
        expect_at(1, ev(2'd2, 0, 1, 1, 1, 1, 0, 1, 0, 0), "R4 lvd keeps full");
        tick(); rst_req = 1;
        expect_at(1, RUN_ALL, "R10 reset from stop again");

        // R4 R8 debug-enabled stop then background
        tick(); lvd_en = 0; lvd_stop_en = 0; dbg_en = 1;
        osc_stop_en = 0; ics_stop_en = 0; stop_exec = 1;
        expect_at(1, ev(2'd2, 0, 1, 0, 0, 1, 1, 1, 0, 0), "R4 debug keeps full");
        tick(); bkgd_cmd = 1; irq = 1;
        expect_at(1, ev(2'd3, 1, 0, 1, 1, 1, 1, 0, 0, 0), "R8 background entry");
        tick(); irq = 1; stop_exec = 1; wait_exec = 1; dbg_mem_req = 1;
        expect_at(1, ev(2'd3, 1, 0, 1, 1, 1, 1, 0, 0, 1), "R10 R9 background holds, access ok");
        tick(); rst_req = 1; bkgd_cmd = 1;
        expect_at(1, RUN_ALL, "R10 leave background");

        // R1 stop beats wait
        tick(); dbg_en = 0; wait_exec = 1; stop_exec = 1;
        expect_at(1, ev(2'd2, 0, 1, 0, 0, 0, 0, 1, 0, 0), "R1 stop wins");
        tick(); rst_req = 1;
        expect_at(1, RUN_ALL, "R10 final reset");

        repeat (3) tick();
        if (sb.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: actual %0d left expected 0", sb.size());
        end
        summary();
        $finish;
    end

endmodule